// File: doc/BRIEF.md
# Control and GPIO Register Block

A bus-slave peripheral that holds a small set of 16-bit control words and sixteen general-purpose I/O lines. A host reaches it through a simple synchronous register port: select, write enable, address, write data and registered read data. It decodes a window of 32-bit-aligned word offsets. Seven of those offsets are plain storage words for mode, clock divide, clock control, interrupt request, interrupt mask, interrupt status and power. One read-only status word returns a fixed reset pattern. Three offsets serve the GPIO lines.

Each GPIO line has a direction bit. The driven level of a line is its bit in the shared level word ANDed with its direction bit. The output pins and a per-line change strobe move only when the host writes direction or level, and the strobe marks only the lines whose driven value actually changed. Input pins pass through a two-flop synchronizer. After that, a change on an input pin overwrites its own bit of the level word without moving the outputs.

Top module: `ctlio_regblk`

## Requirements
- R1: Only address bits [5:0] are decoded; upper address bits are ignored. Offsets: 0x00 mode, 0x04 clock divide, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level write, 0x28 level read.
- R2: Only write data bits [15:0] are stored. The mode, clock divide, clock control and three interrupt words read back exactly what was last written.
- R3: The status word reads 0x0002, and a write to it changes nothing.
- R4: A power write stores the value. When written bit 7 is 1, stored bits 15 and 6 are also set (value | 0x8040).
- R5: A write to 0x24 or 0x28 stores (data & direction) as the level word. Reads of 0x24 and 0x28 both return the level word, and a read of 0x20 returns direction.
- R6: On the clock edge that takes a direction or level write, pin_out becomes level & direction. In the following cycle pin_chg is high only on bits whose pin_out value changed, and it is low in every other cycle.
- R7: An input pin change reaches its level bit on the third rising edge after it is applied, through a two-flop synchronizer. It never moves pin_out or pin_chg.
- R8: When a level write and a synchronized input change reach the same bit on the same edge, the bus write value is stored.
- R9: After reset, every word is zero except status (0x0002), and pin_out, pin_chg, bus_rdata and bus_err are zero.
- R10: bus_rdata carries the read value in the cycle after a read request. It is zero in a cycle that follows no read, and a read of an undecoded offset returns zero.
- R11: bus_err is high for one cycle after any access (read or write) to an undecoded offset, including non-word-aligned offsets. An undecoded write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; only bits [5:0] decoded |
| bus_wdata | input | BUS_DW (32) | Write data; bits [15:0] used |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an undecoded access |
| pin_in | input | GPIO_W (16) | Asynchronous input lines |
| pin_out | output | GPIO_W (16) | Driven output levels |
| pin_chg | output | GPIO_W (16) | Per-line change strobe |

## Verification
The bench drives direction and level sequences that turn lines on, turn them off and leave them unchanged. A design that strobes every direction-enabled line on each write, or that ignores direction when it drives or stores, then shows extra strobe bits or leaking outputs. It writes the power word with bit 7 both set and clear, writes the status word, and accesses unaligned and high-aliased addresses; a decoder that looks at too many bits, or that takes misaligned offsets as valid, shows up there. Input pins are toggled with nothing else happening, to show that the outputs stay still. They are also toggled so that the synchronized change lands on the same edge as a level write, which exposes a merge order that lets the input win.

// File: rtl/ctlio_pkg.sv
package ctlio_pkg;
  localparam int REG_W     = 16;
  localparam int OFF_W     = 6;
  localparam int NREG      = 11;
  localparam int PWR_EN    = 7;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
  localparam logic [REG_W-1:0] STATUS_RST = 16'h0002;

  // word index = offset / 4; index order is the offset order
  typedef enum int {
    IX_MODE = 0, IX_CDIV = 1, IX_STAT = 2, IX_PWR = 3, IX_CCTL = 4,
    IX_IREQ = 5, IX_IMSK = 6, IX_ISTS = 7, IX_DIR = 8, IX_LVW = 9, IX_LVR = 10
  } reg_ix_e;

  function automatic logic [REG_W-1:0] pwr_fold(input logic [REG_W-1:0] v);
    return v[PWR_EN] ? (v | PWR_FORCE) : v;
  endfunction
endpackage

// File: rtl/ctlio_decode.sv
module ctlio_decode
  import ctlio_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output logic [NREG-1:0]  hit,
  output logic             valid
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (off == OFF_W'(i * 4));
  end
  assign valid = |hit;
endmodule

// File: rtl/ctlio_insync.sv
module ctlio_insync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sync_val,
  output logic [W-1:0] sync_chg
);
  logic [W-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pin_in;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_val = stg[STAGES-1];
  assign sync_chg = stg[STAGES-1] ^ stg[STAGES];
endmodule

// File: rtl/ctlio_gpio.sv
module ctlio_gpio #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] in_val,
  input  logic [W-1:0] in_chg,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_chg
);
  logic [W-1:0] lvl_in, lvl_nxt, dir_nxt, eff_nxt;
  logic         upd;

  // per-line merge of synchronized input changes
  for (genvar b = 0; b < W; b++) begin : g_merge
    assign lvl_in[b] = in_chg[b] ? in_val[b] : lvl_q[b];
  end

  // bus write overrides the input merge
  assign lvl_nxt = lvl_we ? (wd & dir_q) : lvl_in;
  assign dir_nxt = dir_we ? wd : dir_q;
  assign eff_nxt = lvl_nxt & dir_nxt;
  assign upd     = dir_we | lvl_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      lvl_q   <= '0;
      pin_out <= '0;
      pin_chg <= '0;
    end else begin
      dir_q   <= dir_nxt;
      lvl_q   <= lvl_nxt;
      pin_chg <= upd ? (pin_out ^ eff_nxt) : '0;
      if (upd) pin_out <= eff_nxt;
    end
  end
endmodule

// File: rtl/ctlio_regblk.sv
module ctlio_regblk
  import ctlio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_DW = 32,
  parameter int GPIO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic [GPIO_W-1:0] pin_in,
  output logic [GPIO_W-1:0] pin_out,
  output logic [GPIO_W-1:0] pin_chg
);
  logic [NREG-1:0]   hit;
  logic              dec_ok, wr_w, rd_w;
  logic [REG_W-1:0]  wd;
  logic [REG_W-1:0]  mode_q, cdiv_q, pwr_q, cctl_q, ireq_q, imsk_q, ists_q;
  logic [GPIO_W-1:0] dir_q, lvl_q, s_val, s_chg;
  logic [REG_W-1:0]  view [NREG];
  logic [REG_W-1:0]  rd_val;

  // observation wires for the checker
  logic              pwr_fold_ev;
  logic [GPIO_W-1:0] dir_w;
  logic [REG_W-1:0]  pwr_w;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[BUS_DW-1:REG_W]};

  ctlio_decode u_dec (.off(bus_addr[OFF_W-1:0]), .hit(hit), .valid(dec_ok));

  assign wr_w = bus_sel & bus_we;
  assign rd_w = bus_sel & ~bus_we;
  assign wd   = bus_wdata[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; cdiv_q <= '0; pwr_q <= '0; cctl_q <= '0;
      ireq_q <= '0; imsk_q <= '0; ists_q <= '0;
    end else if (wr_w) begin
      if (hit[IX_MODE]) mode_q <= wd;
      if (hit[IX_CDIV]) cdiv_q <= wd;
      if (hit[IX_PWR])  pwr_q  <= pwr_fold(wd);
      if (hit[IX_CCTL]) cctl_q <= wd;
      if (hit[IX_IREQ]) ireq_q <= wd;
      if (hit[IX_IMSK]) imsk_q <= wd;
      if (hit[IX_ISTS]) ists_q <= wd;
    end
  end

  ctlio_insync #(.W(GPIO_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .sync_val(s_val), .sync_chg(s_chg)
  );

  ctlio_gpio #(.W(GPIO_W)) u_gpio (
    .clk(clk), .rst_n(rst_n),
    .dir_we(wr_w & hit[IX_DIR]),
    .lvl_we(wr_w & (hit[IX_LVW] | hit[IX_LVR])),
    .wd(wd[GPIO_W-1:0]), .in_val(s_val), .in_chg(s_chg),
    .dir_q(dir_q), .lvl_q(lvl_q), .pin_out(pin_out), .pin_chg(pin_chg)
  );

  assign view[IX_MODE] = mode_q;
  assign view[IX_CDIV] = cdiv_q;
  assign view[IX_STAT] = STATUS_RST;
  assign view[IX_PWR]  = pwr_q;
  assign view[IX_CCTL] = cctl_q;
  assign view[IX_IREQ] = ireq_q;
  assign view[IX_IMSK] = imsk_q;
  assign view[IX_ISTS] = ists_q;
  assign view[IX_DIR]  = REG_W'(dir_q);
  assign view[IX_LVW]  = REG_W'(lvl_q);
  assign view[IX_LVR]  = REG_W'(lvl_q);

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_val = view[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_w ? rd_val : '0;
      bus_err   <= bus_sel & ~dec_ok;
    end
  end

  assign pwr_fold_ev = wr_w & hit[IX_PWR] & wd[PWR_EN];
  assign dir_w       = dir_q;
  assign pwr_w       = pwr_q;
endmodule

// File: rtl/ctlio_regblk_chk.sv
module ctlio_regblk_chk #(
  parameter int GPIO_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_err,
  input logic [15:0]       bus_rdata,
  input logic [GPIO_W-1:0] pin_out,
  input logic [GPIO_W-1:0] pin_chg,
  input logic [GPIO_W-1:0] dir_w,
  input logic [15:0]       pwr_w,
  input logic              pwr_fold_ev
);
  // R6
  out_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~dir_w) == '0);

  // R6
  chg_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg == (pin_out ^ $past(pin_out)));

  // R4
  pwr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fold_ev |=> (pwr_w[15] && pwr_w[6]));

  // R11
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && !bus_we) |-> bus_rdata == '0);
endmodule

bind ctlio_regblk ctlio_regblk_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_err(bus_err), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_chg(pin_chg), .dir_w(dir_w), .pwr_w(pwr_w), .pwr_fold_ev(pwr_fold_ev)
);

// File: tb/ctlio_regblk_tb.sv
module ctlio_regblk_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pins = '0;
  logic [15:0] rdata, pout, pchg;
  logic        err;

  int    checks = 0, errors = 0;
  bit    running = 1'b0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlio_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
    .pin_in(pins), .pin_out(pout), .pin_chg(pchg)
  );

  // behavioural reference
  logic [15:0] m_word [int];
  logic [15:0] m_dir, m_lvl, m_out, m_chg, m_rd;
  logic        m_err;
  logic [15:0] hist [$];

  task automatic model_reset();
    m_word.delete();
    m_dir = 0; m_lvl = 0; m_out = 0; m_chg = 0; m_rd = 0; m_err = 0;
    hist = '{16'h0, 16'h0, 16'h0};
  endtask

  function automatic logic [15:0] m_read(int off);
    if (off == 8'h08) return 16'h0002;
    if (off == 8'h20) return m_dir;
    if (off == 8'h24 || off == 8'h28) return m_lvl;
    if (m_word.exists(off)) return m_word[off];
    return 16'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int off; bit ok; logic [15:0] d, nl, nd, ch, ne;
      off = int'(addr[5:0]);
      ok  = (off % 4 == 0) && (off <= 8'h28);
      d   = wdata[15:0];
      ch  = hist[1] ^ hist[2];
      nl  = (m_lvl & ~ch) | (hist[1] & ch);
      nd  = m_dir;
      m_rd  = (sel && !we && ok) ? m_read(off) : 16'h0;
      m_err = sel && !ok;
      m_chg = 16'h0;
      if (sel && we && ok) begin
        if (off == 8'h20) nd = d;
        else if (off == 8'h24 || off == 8'h28) nl = d & m_dir;
        else if (off == 8'h0C) m_word[off] = d[7] ? (d | 16'h8040) : d;
        else if (off != 8'h08) m_word[off] = d;
        if (off == 8'h20 || off == 8'h24 || off == 8'h28) begin
          ne    = nl & nd;
          m_chg = m_out ^ ne;
          m_out = ne;
        end
      end
      m_lvl = nl; m_dir = nd;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(cur_req, "bus_rdata", rdata, m_rd);
      chk(cur_req, "bus_err", err, m_err);
      chk(cur_req, "pin_out", pout, m_out);
      chk(cur_req, "pin_chg", pchg, m_chg);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string rq);
    cur_req = rq; sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string rq);
    cur_req = rq; sel = 1; we = 0; addr = a; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic idle(input int n, input string rq);
    cur_req = rq;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 explicit reset state
    chk("R9", "pin_out", pout, 16'h0);
    chk("R9", "bus_rdata", rdata, 16'h0);
    chk("R9", "bus_err", err, 1'b0);
    running = 1'b1;
    for (int o = 0; o <= 8'h28; o += 4) rd(12'(o), "R9");
    idle(1, "R10");
    chk("R3", "status after reset", 16'h0002, m_read(8'h08));

    // R2 storage words and truncation
    wr(12'h000, 32'hFFFF_1234, "R2"); rd(12'h000, "R2");
    wr(12'h004, 32'h0001_ABCD, "R2"); rd(12'h004, "R2");
    wr(12'h010, 32'h0000_5A5A, "R2"); rd(12'h010, "R2");
    wr(12'h014, 32'h0000_0F0F, "R2"); rd(12'h014, "R2");
    wr(12'h018, 32'h0000_00FF, "R2"); rd(12'h018, "R2");
    wr(12'h01C, 32'h0000_8001, "R2"); rd(12'h01C, "R2");
    // R1 aliasing of upper address bits
    wr(12'hFC0, 32'h0000_7777, "R1"); rd(12'h000, "R1"); rd(12'h540, "R1");
    // R3 status write ignored
    wr(12'h008, 32'h0000_FFFF, "R3"); rd(12'h008, "R3");
    // R4 power fold
    wr(12'h00C, 32'h0000_0081, "R4"); rd(12'h00C, "R4");
    wr(12'h00C, 32'h0000_0101, "R4"); rd(12'h00C, "R4");
    wr(12'h00C, 32'h0000_FFFF, "R4"); rd(12'h00C, "R4");
    // R11 undecoded and misaligned accesses
    wr(12'h002, 32'h0000_FFFF, "R11"); rd(12'h000, "R11");
    wr(12'h02C, 32'h0000_FFFF, "R11"); rd(12'h03C, "R11");
    rd(12'h005, "R10"); rd(12'h030, "R10");
    idle(2, "R10");
    // R5 level write masked by direction
    wr(12'h024, 32'h0000_FFFF, "R5"); rd(12'h024, "R5");
    wr(12'h020, 32'h0000_00F0, "R6"); rd(12'h020, "R5");
    wr(12'h024, 32'h0000_FF3C, "R5"); rd(12'h024, "R5"); rd(12'h028, "R5");
    // R6 strobe only on changed lines
    wr(12'h020, 32'h0000_0FF0, "R6"); idle(1, "R6");
    wr(12'h028, 32'h0000_0FF0, "R6"); idle(1, "R6");
    wr(12'h028, 32'h0000_0FF0, "R6"); idle(1, "R6");
    wr(12'h020, 32'h0000_00FF, "R6");
    wr(12'h024, 32'h0000_0055, "R6");
    wr(12'h020, 32'h0000_FFFF, "R6"); idle(2, "R6");
    // R7 input pins reach level without moving outputs
    pins = 16'hA500; idle(4, "R7"); rd(12'h028, "R7");
    pins = 16'h0000; idle(1, "R7"); rd(12'h024, "R7"); idle(2, "R7"); rd(12'h024, "R7");
    wr(12'h020, 32'h0000_FF00, "R7"); rd(12'h024, "R7");
    // R8 bus write and synchronized input land on the same edge
    pins = 16'h0003; idle(2, "R8");
    wr(12'h024, 32'h0000_0000, "R8"); rd(12'h024, "R8");
    wr(12'h020, 32'h0000_FFFF, "R8");
    pins = 16'h0000; idle(2, "R8");
    wr(12'h024, 32'h0000_0001, "R8"); rd(12'h024, "R8");
    idle(3, "R8"); rd(12'h024, "R8");
    idle(2, "R10");
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule